// File: doc/BRIEF.md
# MDIO Management Responder (PHY Side)

This block is the station-facing end of a two-wire serial management link, placed inside a PHY. It runs directly on the management clock and samples the data line on every rising edge. It waits for a run of at least 32 ones, then a start pattern, and then decodes a two-bit operation code, a five-bit device address and a five-bit register address. When the device address equals the value on the strap pins, the block either returns sixteen bits from its register store or takes sixteen bits into it.

The register store holds ten 16-bit words, for register addresses 0 to 6 and 16 to 18. Every other address reads as zero, and writes to those addresses are dropped. The data line is shared with up to 31 other devices. The block therefore drives it only through an output enable, and only in the turnaround and data slots of a read addressed to it. Between frames the line floats and an external pull-up holds it high.

Top module: `mdio_responder`

## Requirements
- R1: After reset the output enable is low and no register access happens until a full frame has been received.
- R2: A frame is accepted only if at least 32 consecutive ones are sampled directly before the start pattern 0 then 1. A frame with fewer ones causes no drive and no write.
- R3: The operation code is taken most significant bit first: 1,0 means read and 0,1 means write. A frame carrying 0,0 or 1,1 causes no drive and no write.
- R4: On a read, the enable stays low during the first turnaround bit. During the second turnaround bit the block drives 0. It then drives data bits 15 down to 0. Each value is updated just after an MDC rising edge and holds until the next rising edge.
- R5: The block drives the line, and accepts writes, only when the five-bit device address, taken MSB first, equals the strap input.
- R6: On a write, the two turnaround bits are skipped. The next 16 sampled bits, MSB first, are stored in the addressed register, and a later read returns them.
- R7: The enable is high for exactly 17 bit periods per read (turnaround zero plus 16 data bits). It falls right after the period of data bit 0.
- R8: A read of any address other than 0–6 or 16–18 returns 0x0000. A write to such an address changes no register.
- R9: Registers 0–6 and 16–18 each hold their own value, independently of the others.
- R10: The ones count is cleared at the end of every frame, so a new frame again needs 32 fresh ones before its start pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phy_addr_strap | input | 5 | Device address this responder answers to |
| mdio_in | input | 1 | Sampled value of the shared data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable of the data line tri-state driver |

## Verification
Some properties are checked on every cycle. The enable is raised only for a frame whose captured address equals the strap, and its first driven bit is zero. It never stays high for more than 17 periods and falls only when the parser is back to hunting. A start pattern is entered only after the ones count is full. Writes happen only on write frames, and a write to an unimplemented address leaves the whole store unchanged. Other behaviour shows only in the bench's frame scenarios: the actual data values returned, rejection of short preambles and bad opcodes, the fresh-preamble rule between back-to-back frames, and the independence of the ten stored registers.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned CNT_W     = 4;
  localparam int unsigned LOW_LAST  = 6;
  localparam int unsigned VEND_FIRST = 16;
  localparam int unsigned VEND_LAST  = 18;
  localparam int unsigned NUM_REGS  = (LOW_LAST + 1) + (VEND_LAST - VEND_FIRST + 1);
  localparam int unsigned SLOT_W    = $clog2(NUM_REGS);

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SFD,
    ST_OP,
    ST_PHY,
    ST_REG,
    ST_TA1,
    ST_TA2,
    ST_DATA
  } frame_st_e;

endpackage

// File: rtl/mdio_preamble_det.sv
module mdio_preamble_det #(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunt,
  input  logic bit_in,
  output logic pre_ok
);
  localparam int unsigned PC_W = $clog2(PRE_LEN + 1);
  localparam logic [PC_W-1:0] PC_MAX = PC_W'(PRE_LEN);

  logic [PC_W-1:0] ones_q, ones_d;

  always_comb begin
    ones_d = ones_q;
    if (!hunt) begin
      ones_d = '0;
    end else if (bit_in) begin
      if (ones_q != PC_MAX) ones_d = ones_q + 1'b1;
    end else begin
      ones_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assign pre_ok = (ones_q == PC_MAX);

  p_ones_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= PC_MAX);

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic              hit;
  logic [SLOT_W-1:0] slot;
  logic [NUM_REGS-1:0][DATA_W-1:0] store;

  always_comb begin
    hit  = 1'b0;
    slot = '0;
    if (addr <= ADDR_W'(LOW_LAST)) begin
      hit  = 1'b1;
      slot = SLOT_W'(addr);
    end else if (addr >= ADDR_W'(VEND_FIRST) && addr <= ADDR_W'(VEND_LAST)) begin
      hit  = 1'b1;
      slot = SLOT_W'(addr - ADDR_W'(VEND_FIRST - LOW_LAST - 1));
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic              en;
    logic [DATA_W-1:0] q;
    assign en = wr_en && hit && (slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign store[g] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit && slot == SLOT_W'(i)) rd_data = store[i];
    end
  end

  // R8: a write aimed outside the implemented set leaves all words untouched
  p_unimpl_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(store));

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic [ADDR_W-1:0] phy_strap,
  input  logic              pre_ok,
  input  logic [DATA_W-1:0] rd_data,
  output logic              hunt,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam logic [CNT_W-1:0] LAST_OP   = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

  frame_st_e         state_q, state_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [1:0]        op_q, op_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] reg_q, reg_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              out_q, out_d;
  logic              is_read;

  assign is_read = (op_q == OP_READ);

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    op_d    = op_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    out_d   = out_q;
    wr_en   = 1'b0;
    wr_data = {sh_q[DATA_W-2:0], mdio_in};
    unique case (state_q)
      ST_HUNT: begin
        if (!mdio_in && pre_ok) state_d = ST_SFD;
      end
      ST_SFD: begin
        bcnt_d  = '0;
        state_d = mdio_in ? ST_OP : ST_HUNT;
      end
      ST_OP: begin
        op_d = {op_q[0], mdio_in};
        if (bcnt_q == LAST_OP) begin
          bcnt_d  = '0;
          state_d = (op_d == OP_READ || op_d == OP_WRITE) ? ST_PHY : ST_HUNT;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
      ST_PHY: begin
        phy_d = {phy_q[ADDR_W-2:0], mdio_in};
        if (bcnt_q == LAST_ADDR) begin
          bcnt_d  = '0;
          state_d = (phy_d == phy_strap) ? ST_REG : ST_HUNT;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
      ST_REG: begin
        reg_d = {reg_q[ADDR_W-2:0], mdio_in};
        if (bcnt_q == LAST_ADDR) begin
          bcnt_d  = '0;
          state_d = ST_TA1;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
        end
      end
      ST_TA1: begin
        state_d = ST_TA2;
        if (is_read) begin
          oe_d  = 1'b1;
          out_d = 1'b0;
          sh_d  = rd_data;
        end
      end
      ST_TA2: begin
        state_d = ST_DATA;
        bcnt_d  = '0;
        if (is_read) begin
          out_d = sh_q[DATA_W-1];
          sh_d  = {sh_q[DATA_W-2:0], 1'b0};
        end
      end
      ST_DATA: begin
        bcnt_d = bcnt_q + 1'b1;
        if (is_read) begin
          if (bcnt_q == LAST_DATA) begin
            oe_d    = 1'b0;
            out_d   = 1'b1;
            state_d = ST_HUNT;
          end else begin
            out_d = sh_q[DATA_W-1];
            sh_d  = {sh_q[DATA_W-2:0], 1'b0};
          end
        end else begin
          sh_d = {sh_q[DATA_W-2:0], mdio_in};
          if (bcnt_q == LAST_DATA) begin
            wr_en   = 1'b1;
            state_d = ST_HUNT;
          end
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      bcnt_q  <= '0;
      op_q    <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      op_q    <= op_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      out_q   <= out_d;
    end
  end

  assign hunt     = (state_q == ST_HUNT);
  assign reg_addr = reg_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;

  logic [4:0] oe_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    oe_run_q <= '0;
    else if (oe_q) oe_run_q <= oe_run_q + 1'b1;
    else           oe_run_q <= '0;
  end

  p_sfd_needs_preamble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SFD) |-> $past(pre_ok));

  p_no_write_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (op_q == OP_WRITE));

  p_ta_drive_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !out_q);

  p_oe_own_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (phy_q == phy_strap));

  p_oe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (oe_run_q < 5'd17));

  p_oe_release_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> (state_q == ST_HUNT));

endmodule

// File: rtl/mdio_responder.sv
module mdio_responder
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] phy_addr_strap,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe
);
  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              hunt;
  logic              pre_ok;
  logic [ADDR_W-1:0] reg_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  mdio_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk    (mdc),
    .rst_n  (core_rst_n),
    .hunt   (hunt),
    .bit_in (mdio_in),
    .pre_ok (pre_ok)
  );

  mdio_frame_ctrl u_ctrl (
    .clk       (mdc),
    .rst_n     (core_rst_n),
    .mdio_in   (mdio_in),
    .phy_strap (phy_addr_strap),
    .pre_ok    (pre_ok),
    .rd_data   (rd_data),
    .hunt      (hunt),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe)
  );

  mdio_regfile u_regs (
    .clk     (mdc),
    .rst_n   (core_rst_n),
    .addr    (reg_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  // R1: the line is never driven while reset is held
  p_reset_quiet_r1: assert property (@(posedge mdc)
    !core_rst_n |=> !mdio_oe);

endmodule

// File: tb/tb_mdio_responder.sv
module tb_mdio_responder;
  localparam logic [4:0] STRAP = 5'h0B;

  logic mdc = 1'b0;
  always #5 mdc = ~mdc;

  logic rst_n;
  logic st_en, st_drv;
  logic mdio_out, mdio_oe;
  logic bus;

  assign bus = mdio_oe ? mdio_out : (st_en ? st_drv : 1'b1);

  mdio_responder dut (
    .mdc            (mdc),
    .rst_n          (rst_n),
    .phy_addr_strap (STRAP),
    .mdio_in        (bus),
    .mdio_out       (mdio_out),
    .mdio_oe        (mdio_oe)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [15:0] model [32];

  function automatic bit implemented(input logic [4:0] a);
    return (a <= 5'd6) || (a >= 5'd16 && a <= 5'd18);
  endfunction

  function automatic logic [15:0] expect_read(input logic [4:0] a);
    return implemented(a) ? model[a] : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic b);
    @(negedge mdc);
    st_en  = 1'b1;
    st_drv = b;
  endtask

  task automatic frame(input int npre, input bit brk, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, input bit resp,
                       input logic [15:0] exp_rd, input string req);
    logic [15:0] got;
    if (brk) begin put(1'b0); put(1'b0); end
    repeat (npre) put(1'b1);
    put(1'b0); put(1'b1);
    for (int i = 1; i >= 0; i--) put(op[i]);
    for (int i = 4; i >= 0; i--) put(phy[i]);
    for (int i = 4; i >= 0; i--) put(ra[i]);
    if (op == 2'b10) begin
      got = '0;
      @(negedge mdc); st_en = 1'b0;
      check(mdio_oe == 1'b0, {req, " R4 first turnaround released"}, 32'(mdio_oe), 0);
      @(negedge mdc);
      if (resp) check(mdio_oe && !mdio_out, {req, " R4 turnaround zero"}, {mdio_oe, mdio_out}, 32'h2);
      else      check(!mdio_oe, {req, " R5 no drive for other address"}, 32'(mdio_oe), 0);
      for (int i = 15; i >= 0; i--) begin
        @(negedge mdc);
        if (resp) begin
          if (!mdio_oe) check(1'b0, {req, " R7 enable held through data"}, 0, 1);
          got[i] = mdio_out;
        end else if (mdio_oe) begin
          check(1'b0, {req, " R5 no drive in data slot"}, 1, 0);
        end
      end
      if (resp) check(got == exp_rd, {req, " R4 read data"}, 32'(got), 32'(exp_rd));
      @(negedge mdc);
      check(mdio_oe == 1'b0, {req, " R7 enable drops after bit 0"}, 32'(mdio_oe), 0);
    end else begin
      put(1'b1); put(1'b0);
      for (int i = 15; i >= 0; i--) put(wd[i]);
      @(negedge mdc); st_en = 1'b0;
    end
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] d);
    frame(32, 1'b1, 2'b01, STRAP, ra, d, 1'b0, 16'h0, "wr");
    if (implemented(ra)) model[ra] = d;
  endtask

  task automatic rd(input logic [4:0] ra, input string req);
    frame(32, 1'b1, 2'b10, STRAP, ra, 16'h0, 1'b1, expect_read(ra), req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'h00C0FFEE);
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    st_en = 1'b0; st_drv = 1'b1; rst_n = 1'b0;
    repeat (4) @(negedge mdc);
    check(mdio_oe == 1'b0, "R1 enable low in reset", 32'(mdio_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge mdc);
    check(mdio_oe == 1'b0, "R1 enable low after reset", 32'(mdio_oe), 0);
    rd(5'd0, "R1 reset value");

    wr(5'd3, 16'hA5C3);
    rd(5'd3, "R6 write then read");
    wr(5'd18, 16'h8001);
    rd(5'd18, "R6 vendor register");

    // R2: 31 ones only
    frame(31, 1'b1, 2'b01, STRAP, 5'd3, 16'h1234, 1'b0, 16'h0, "R2 short preamble write");
    rd(5'd3, "R2 short preamble ignored");
    frame(31, 1'b1, 2'b10, STRAP, 5'd3, 16'h0, 1'b0, 16'h0, "R2 short preamble read");

    // R3: invalid opcodes
    frame(32, 1'b1, 2'b00, STRAP, 5'd3, 16'h1111, 1'b0, 16'h0, "R3 op00");
    frame(32, 1'b1, 2'b11, STRAP, 5'd3, 16'h2222, 1'b0, 16'h0, "R3 op11");
    rd(5'd3, "R3 bad opcode ignored");

    // R5: other device address
    frame(32, 1'b1, 2'b01, STRAP ^ 5'h01, 5'd3, 16'h3333, 1'b0, 16'h0, "R5 foreign write");
    rd(5'd3, "R5 foreign write ignored");
    frame(32, 1'b1, 2'b10, STRAP ^ 5'h10, 5'd3, 16'h0, 1'b0, 16'h0, "R5 foreign read");

    // R8: unimplemented addresses
    wr(5'd7, 16'hDEAD);
    wr(5'd15, 16'hBEEF);
    wr(5'd19, 16'hCAFE);
    rd(5'd7, "R8 unimplemented reads zero");
    rd(5'd19, "R8 unimplemented reads zero");
    rd(5'd6, "R8 neighbour intact");
    rd(5'd16, "R8 neighbour intact");

    // R10: back-to-back frame without fresh preamble
    wr(5'd1, 16'h0F0F);
    frame(20, 1'b0, 2'b01, STRAP, 5'd1, 16'hF0F0, 1'b0, 16'h0, "R10 stale preamble");
    rd(5'd1, "R10 second frame ignored");

    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      int kind;
      logic [4:0] phy, ra;
      logic [15:0] d;
      kind = $urandom_range(0, 9);
      phy  = ($urandom_range(0, 4) == 0) ? 5'($urandom_range(0, 31)) : STRAP;
      ra   = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31))
           : (($urandom_range(0, 1) == 0) ? 5'($urandom_range(0, 6)) : 5'($urandom_range(16, 18)));
      d    = 16'($urandom);
      if (kind < 5) begin
        frame(32, 1'b1, 2'b01, phy, ra, d, 1'b0, 16'h0, "R6 random write");
        if (phy == STRAP && implemented(ra)) model[ra] = d;
      end else if (kind < 9) begin
        frame(32, 1'b1, 2'b10, phy, ra, 16'h0, phy == STRAP, expect_read(ra), "R9 random read");
      end else begin
        frame(32, 1'b1, ($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11, phy, ra, d, 1'b0, 16'h0, "R3 random bad op");
      end
    end

    // R9: fill every address, then read all back
    for (int a = 0; a < 32; a++) wr(5'(a), 16'h1000 + 16'(a * 16'h0111));
    for (int a = 0; a < 32; a++) rd(5'(a), "R9 independent registers");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule